// File: doc/BRIEF.md
# Steerable Interrupt Line with Event Status Queue

This block collects internal event pulses, keeps a record of them in a small status queue, and raises one interrupt line toward the host. The host chooses which of four interrupt output pins carries that line by writing a pin number into a select register. Pins that are not chosen are left undriven. Each pin has its own output value and its own output enable, so a pad ring can build a real tri-state driver from them.

A cycle in which any enabled event pulses pushes one 16-bit word into the queue. In that word, bit i is set when event i fired and its enable bit was set. The host services the interrupt by popping words until the queue reports 0x0000. That all-zero read is what drops the line. A new event that lands in the same cycle keeps the line up.

Top module: `irq_steer`

## Requirements
- R1: After reset, all four pin enables and pin values are 0, and a queue read returns 0x0000.
- R2: A write of a value from 0 to 3 to the select address 0x0022 drives exactly pin number `value` from the next cycle on (its `irq_oe` bit is 1), and every other pin's enable is 0.
- R3: A write to the select address of any value above 3 turns all four pin enables off from the next cycle on.
- R4: Writes to any address other than 0x0022 leave the pin selection unchanged.
- R5: When any event pulses with its enable bit set, the selected pin's value is 1 from the next cycle on.
- R6: An event whose enable bit is clear neither queues a word nor raises the line.
- R7: Each cycle with at least one enabled event pushes one word whose bit i is 1 when event i pulsed with its enable set, and whose upper bits are 0. Words are read back in arrival order. `q_rdata` shows the head word in the cycle that `q_rd` is high, and the pop takes place at that clock edge.
- R8: A read that returns a nonzero word leaves the line high. A read that returns 0x0000 (the queue is empty) drops the line in the next cycle.
- R9: If an enabled event arrives in the same cycle as a zero-returning read, the line stays high.
- R10: The queue holds 8 words. A word pushed while 8 words are unread is discarded, and the line still rises.
- R11: At most one pin enable is 1 at any time, and a pin whose enable is 0 has value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 8 | One-cycle event pulses, one bit per event |
| evt_en | input | 8 | Per-event enable bits |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| q_rd | input | 1 | Pop one word from the status queue |
| q_rdata | output | 16 | Head word of the queue, 0x0000 when empty |
| irq_o | output | 4 | Value of each interrupt pin |
| irq_oe | output | 4 | Output enable of each interrupt pin |

## Verification
The bench goes after the clearing rule. A design that dropped the line on any read would lose an interrupt while nonzero words were still pending. A design that ignored an event arriving in the same cycle as the zero read would leave an unserviced word in the queue with the line low. It also checks out-of-range and misaddressed select writes: a decoder that used only the low bits would drive a pin for the value 0x0104, and one that ignored the address would move the line on unrelated writes. Overfilling the queue shows whether a full queue overwrites old words or corrupts their order. Masked events show whether the enable gates both the queue and the line.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   parameter int DEF_NUM_EVT  = 8;
   parameter int DEF_WORD_W   = 16;
   parameter int DEF_Q_DEPTH  = 8;
   parameter int DEF_NUM_PINS = 4;
   parameter int DEF_ADDR_W   = 16;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/evt_gather.sv
module evt_gather #(
   parameter int NUM_EVT = 8,
   parameter int WORD_W  = 16
) (
   input  logic [NUM_EVT-1:0] pulse,
   input  logic [NUM_EVT-1:0] en,
   output logic [WORD_W-1:0]  word,
   output logic               hit
);
   localparam int PAD_W = WORD_W - NUM_EVT;

   generate
      if (NUM_EVT > WORD_W) begin : g_bad_width
         $error("evt_gather: NUM_EVT must not exceed WORD_W");
      end
   endgenerate

   logic [NUM_EVT-1:0] live;
   assign live = pulse & en;
   assign hit  = |live;

   generate
      if (PAD_W == 0) begin : g_exact
         assign word = live;
      end else begin : g_pad
         assign word = {{PAD_W{1'b0}}, live};
      end
   endgenerate
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (!irq_steer_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("evt_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] cnt;
   logic          full, do_pop, do_push;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end
endmodule

// File: rtl/pin_steer.sv
module pin_steer #(
   parameter int NUM_PINS = 4,
   parameter int PIN_W    = 2
) (
   input  logic                sel_ok,
   input  logic [PIN_W-1:0]    sel_idx,
   input  logic                line,
   output logic [NUM_PINS-1:0] pin_val,
   output logic [NUM_PINS-1:0] pin_oe
);
   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         assign pin_oe[p]  = sel_ok && (sel_idx == PIN_W'(p));
         assign pin_val[p] = pin_oe[p] & line;
      end
   endgenerate
endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
   parameter int NUM_EVT  = irq_steer_pkg::DEF_NUM_EVT,
   parameter int WORD_W   = irq_steer_pkg::DEF_WORD_W,
   parameter int Q_DEPTH  = irq_steer_pkg::DEF_Q_DEPTH,
   parameter int NUM_PINS = irq_steer_pkg::DEF_NUM_PINS,
   parameter int ADDR_W   = irq_steer_pkg::DEF_ADDR_W,
   parameter logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'('h22),
   parameter int RST_SEL  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_EVT-1:0]  evt_pulse,
   input  logic [NUM_EVT-1:0]  evt_en,
   input  logic                cfg_we,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [WORD_W-1:0]   cfg_wdata,
   input  logic                q_rd,
   output logic [WORD_W-1:0]   q_rdata,
   output logic [NUM_PINS-1:0] irq_o,
   output logic [NUM_PINS-1:0] irq_oe
);
   localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   generate
      if (NUM_PINS < 1 || NUM_PINS >= (1 << WORD_W)) begin : g_bad_pins
         $error("irq_steer: NUM_PINS out of range");
      end
   endgenerate

   logic [WORD_W-1:0] evt_word;
   logic              evt_hit;
   logic              q_empty;
   logic              sel_ok;
   logic [PIN_W-1:0]  sel_idx;
   logic              irq_q;
   logic              sel_wr;

   evt_gather #(.NUM_EVT(NUM_EVT), .WORD_W(WORD_W)) u_gather (
      .pulse (evt_pulse),
      .en    (evt_en),
      .word  (evt_word),
      .hit   (evt_hit)
   );

   evt_fifo #(.DEPTH(Q_DEPTH), .W(WORD_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (evt_hit),
      .push_data (evt_word),
      .pop       (q_rd),
      .head      (q_rdata),
      .empty     (q_empty)
   );

   assign sel_wr = cfg_we && (cfg_addr == SEL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_ok  <= (RST_SEL >= 0) && (RST_SEL < NUM_PINS);
         sel_idx <= PIN_W'(RST_SEL);
      end else if (sel_wr) begin
         sel_ok  <= (cfg_wdata < WORD_W'(NUM_PINS));
         sel_idx <= cfg_wdata[PIN_W-1:0];
      end
   end

   // Line rises on any enabled event; falls only on a zero-returning read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                irq_q <= 1'b0;
      else if (evt_hit)          irq_q <= 1'b1;
      else if (q_rd && q_empty)  irq_q <= 1'b0;
   end

   pin_steer #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_steer (
      .sel_ok  (sel_ok),
      .sel_idx (sel_idx),
      .line    (irq_q),
      .pin_val (irq_o),
      .pin_oe  (irq_oe)
   );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
   parameter int NUM_EVT  = 8,
   parameter int WORD_W   = 16,
   parameter int NUM_PINS = 4,
   parameter int ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'('h22)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_EVT-1:0]  evt_pulse,
   input logic [NUM_EVT-1:0]  evt_en,
   input logic                cfg_we,
   input logic [ADDR_W-1:0]   cfg_addr,
   input logic [WORD_W-1:0]   cfg_wdata,
   input logic                q_rd,
   input logic [WORD_W-1:0]   q_rdata,
   input logic [NUM_PINS-1:0] irq_o,
   input logic [NUM_PINS-1:0] irq_oe,
   input logic                irq_line,
   input logic                q_empty
);
   logic new_evt, sel_hit;
   assign new_evt = |(evt_pulse & evt_en);
   assign sel_hit = cfg_we && (cfg_addr == SEL_ADDR);

   assert_one_driver_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_oe));

   assert_float_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o & ~irq_oe) == '0);

   assert_sel_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_hit && (cfg_wdata < WORD_W'(NUM_PINS)) |=> $countones(irq_oe) == 1);

   assert_sel_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_hit && (cfg_wdata >= WORD_W'(NUM_PINS)) |=> irq_oe == '0);

   assert_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      new_evt |=> irq_line);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line && q_rd && !q_empty |=> irq_line);

   assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_rd && q_empty && !new_evt |=> !irq_line);

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_line && !new_evt |=> !irq_line);

   assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty |-> q_rdata == '0);
endmodule

bind irq_steer irq_steer_chk #(
   .NUM_EVT(NUM_EVT), .WORD_W(WORD_W), .NUM_PINS(NUM_PINS),
   .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_en(evt_en),
   .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .q_rd(q_rd), .q_rdata(q_rdata), .irq_o(irq_o), .irq_oe(irq_oe),
   .irq_line(irq_q), .q_empty(q_empty)
);

// File: tb/sim_irq_steer.sv
`timescale 1ns/1ps
module sim_irq_steer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_pulse = '0;
   logic [7:0]  evt_en = '0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        q_rd = 1'b0;
   logic [15:0] q_rdata;
   logic [3:0]  irq_o, irq_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   irq_steer u0 (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_en(evt_en),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .q_rd(q_rd), .q_rdata(q_rdata), .irq_o(irq_o), .irq_oe(irq_oe)
   );

   // {pulse, enable, expected queued word}
   localparam logic [31:0] VEC [6] = '{
      {8'h01, 8'hFF, 16'h0001},
      {8'h81, 8'hFF, 16'h0081},
      {8'h0F, 8'h05, 16'h0005},
      {8'h10, 8'hEF, 16'h0000},
      {8'hF0, 8'h30, 16'h0030},
      {8'h00, 8'hFF, 16'h0000}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [15:0] a, input logic [15:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic fire(input logic [7:0] p, input logic [7:0] e);
      evt_pulse = p; evt_en = e;
      @(posedge clk); #1;
      evt_pulse = '0;
   endtask

   task automatic read_q(input string req, input logic [15:0] exp);
      q_rd = 1'b1;
      #0.5;
      check(req, q_rdata, exp);
      @(posedge clk); #1;
      q_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      check("R1 oe", {12'h0, irq_oe}, 16'h0);
      check("R1 val", {12'h0, irq_o}, 16'h0);
      check("R1 queue", q_rdata, 16'h0);

      // R2 each pin selectable, R11 only one enabled
      for (int s = 0; s < 4; s++) begin
         write_cfg(16'h0022, 16'(s));
         check("R2 R11 pick", {12'h0, irq_oe}, 16'(4'b1 << s));
      end
      // R4 other addresses ignored
      write_cfg(16'h0020, 16'h0001);
      write_cfg(16'h0023, 16'h0000);
      check("R4 unchanged", {12'h0, irq_oe}, 16'h8);
      // R3 out of range values
      write_cfg(16'h0022, 16'h0104);
      check("R3 0x104", {12'h0, irq_oe}, 16'h0);
      write_cfg(16'h0022, 16'h0002);
      write_cfg(16'h0022, 16'h0007);
      check("R3 7", {12'h0, irq_oe}, 16'h0);

      // Vector walk: R5 R6 R7 R8
      for (int i = 0; i < 6; i++) begin
         logic [7:0]  p, e;
         logic [15:0] w;
         int          sel;
         {p, e, w} = VEC[i];
         sel = i % 4;
         write_cfg(16'h0022, 16'(sel));
         fire(p, e);
         check("R5 R6 line", {15'h0, irq_o[sel]}, {15'h0, (w != 0)});
         read_q("R7 R6 word", w);
         if (w != 0) begin
            check("R8 hold on nonzero", {15'h0, irq_o[sel]}, 16'h1);
            read_q("R8 zero read", 16'h0);
         end
         check("R8 low after zero", {15'h0, irq_o[sel]}, 16'h0);
      end

      // R9 event in same cycle as zero read
      write_cfg(16'h0022, 16'h0001);
      fire(8'h02, 8'hFF);
      read_q("R7 word", 16'h0002);
      q_rd = 1'b1; evt_pulse = 8'h40;
      #0.5;
      check("R9 zero read", q_rdata, 16'h0);
      @(posedge clk); #1;
      q_rd = 1'b0; evt_pulse = '0;
      check("R9 stays high", {15'h0, irq_o[1]}, 16'h1);
      // R11 deselect while line high
      write_cfg(16'h0022, 16'h0005);
      check("R11 floated val", {12'h0, irq_o}, 16'h0);
      check("R11 floated oe", {12'h0, irq_oe}, 16'h0);
      write_cfg(16'h0022, 16'h0001);
      check("R9 still pending", {12'h0, irq_o}, 16'h2);
      read_q("R9 new word", 16'h0040);
      read_q("R8 zero", 16'h0);
      check("R8 dropped", {12'h0, irq_o}, 16'h0);

      // R10 overfill: ten pushes, eight kept in order
      write_cfg(16'h0022, 16'h0000);
      for (int k = 0; k < 10; k++) fire(8'(k + 1), 8'hFF);
      check("R10 line up", {12'h0, irq_o}, 16'h1);
      for (int k = 0; k < 8; k++) read_q("R10 R7 order", 16'(k + 1));
      check("R10 hold", {12'h0, irq_o}, 16'h1);
      read_q("R10 extra dropped", 16'h0);
      check("R10 low", {12'h0, irq_o}, 16'h0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule